// File: doc/BRIEF.md
# Host Aperture Window Remapper

This block sits behind a 1 MB host-visible aperture and gives the host reach into a 32 MB internal address space. Each host access carries a 20-bit aperture offset, a write flag and write data. The bottom half of the aperture (offsets below 0x80000) is an identity map onto the internal bus. The top half is redirected through a window register. That register holds an enable bit and a 6-bit window number, and the window number supplies the upper internal address bits.

The window register is itself reachable at aperture offset 0x310C, inside the identity-mapped half. It is served locally and never reaches the internal bus. Forwarded accesses go out on a single-outstanding request/acknowledge interface, and every accepted host access ends with a one-cycle completion pulse that carries read data and an error flag.

Top module: `barWindowRemap`

## Requirements
- R1: After reset, the window register reads as zero (window disabled, window number 0), and hostDone, hostErr, hostBusy and intReq are low.
- R2: A request accepted with hostOffset[19]=0 and hostOffset other than 0x310C is forwarded with intAddr equal to the offset zero-extended to 25 bits.
- R3: A request accepted with hostOffset[19]=1 while the window is enabled is forwarded with intAddr = {window[5:0], hostOffset[18:0]}.
- R4: Offset 0x310C is the window register. A write stores hostWdata[31] as the enable and hostWdata[5:0] as the window number. A read returns the enable in bit 31 and the window number in bits 5:0, with bits 30:6 reading as zero. hostDone pulses in the cycle after acceptance, and hostRdata is zero for a write.
- R5: A request to the top half while the enable is clear is not forwarded. hostDone and hostErr both pulse in the cycle after acceptance, hostRdata is zero, and a write is dropped.
- R6: An access to offset 0x310C never raises intReq.
- R7: A window register write is applied to the very next accepted access.
- R8: A forwarded access raises intReq in the cycle after acceptance. intReq then stays high, with intAddr, intWrite and intWdata held stable, through the cycle in which intAck is high. hostDone pulses in the next cycle with hostRdata equal to intRdata sampled with intAck for a read, and zero for a write.
- R9: hostBusy is high exactly while intReq is high. A hostReq raised while hostBusy is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hostReq | input | 1 | Host access request, accepted when hostBusy is low |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostOffset | input | 20 | Aperture offset |
| hostWdata | input | 32 | Host write data |
| hostBusy | output | 1 | A forwarded access is outstanding |
| hostDone | output | 1 | One-cycle completion pulse |
| hostErr | output | 1 | Completion was a disabled-window fault |
| hostRdata | output | 32 | Read data, valid with hostDone |
| intReq | output | 1 | Internal bus request |
| intWrite | output | 1 | Internal bus write flag |
| intAddr | output | 25 | Internal bus address |
| intWdata | output | 32 | Internal bus write data |
| intAck | input | 1 | Internal bus acknowledge |
| intRdata | input | 32 | Internal bus read data, valid with intAck |

## Verification
Register and fault accesses complete one cycle after the accepting edge. A forwarded access raises intReq one cycle after acceptance and completes one cycle after the edge that samples intAck. The bench drives inputs on falling edges. A behavioural model steps on each rising edge and predicts hostDone, hostErr, hostRdata, hostBusy, intReq and the internal address fields for the cycle that follows. These predictions are compared on the next falling edge, so every due cycle is checked exactly and no window of tolerance is allowed. Acknowledge latency is varied from zero to several cycles so that the hold and completion timing are exercised at both extremes.

// File: rtl/barWinPkg.sv
package barWinPkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } winStateT;

  typedef struct packed {
    logic accept;     // latch request fields and start a forwarded access
    logic ctrlWrite;  // update window register
    logic ctrlRead;   // return window register contents
    logic fault;      // top-half access with window disabled
    logic capture;    // internal ack seen, complete forwarded access
  } winStrobeT;

endpackage

// File: rtl/barWinCtrl.sv
module barWinCtrl
  import barWinPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      hostReq,
  input  logic      hostWrite,
  input  logic      hitCtrl,
  input  logic      hitUpper,
  input  logic      winEn,
  input  logic      intAck,
  output winStrobeT strobe,
  output logic      busy
);

  winStateT state, stateNext;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (hostReq) begin
          if (hitCtrl) begin
            strobe.ctrlWrite = hostWrite;
            strobe.ctrlRead  = !hostWrite;
          end else if (hitUpper && !winEn) begin
            strobe.fault = 1'b1;
          end else begin
            strobe.accept = 1'b1;
            stateNext     = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (intAck) begin
          strobe.capture = 1'b1;
          stateNext      = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busy = (state == ST_WAIT);

endmodule

// File: rtl/barWinPath.sv
module barWinPath
  import barWinPkg::*;
#(
  parameter int          APER_W   = 20,
  parameter int          INT_W    = 25,
  parameter int          DATA_W   = 32,
  parameter logic [19:0] CTRL_OFF = 20'h0310C,
  parameter int          EN_POS   = 31
) (
  input  logic              clk,
  input  logic              rstN,
  input  winStrobeT         strobe,
  input  logic              hostWrite,
  input  logic [APER_W-1:0] hostOffset,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [DATA_W-1:0] intRdata,
  output logic              hitCtrl,
  output logic              hitUpper,
  output logic              winEn,
  output logic [INT_W-1:0]  intAddr,
  output logic              intWrite,
  output logic [DATA_W-1:0] intWdata,
  output logic              hostDone,
  output logic              hostErr,
  output logic [DATA_W-1:0] hostRdata
);

  localparam int HALF_W = APER_W - 1;
  localparam int WIN_W  = INT_W - HALF_W;

  logic              winEnQ;
  logic [WIN_W-1:0]  winSelQ;
  logic [INT_W-1:0]  mapAddr;
  logic [DATA_W-1:0] ctrlView;
  logic [DATA_W-1:0] rspData;

  assign hitCtrl  = (hostOffset == CTRL_OFF[APER_W-1:0]);
  assign hitUpper = hostOffset[APER_W-1];
  assign winEn    = winEnQ;

  // Aperture to internal address: identity below the midpoint, window above.
  always_comb begin
    if (hitUpper) mapAddr = {winSelQ, hostOffset[HALF_W-1:0]};
    else          mapAddr = {{WIN_W{1'b0}}, hostOffset[HALF_W-1:0]};
  end

  // Register view: enable at EN_POS, window number in the low bits, rest zero.
  always_comb begin
    ctrlView              = '0;
    ctrlView[EN_POS]      = winEnQ;
    ctrlView[WIN_W-1:0]   = winSelQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winEnQ  <= 1'b0;
      winSelQ <= '0;
    end else if (strobe.ctrlWrite) begin
      winEnQ  <= hostWdata[EN_POS];
      winSelQ <= hostWdata[WIN_W-1:0];
    end
  end

  // Forwarded request fields: loaded at acceptance, held until completion.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intAddr  <= '0;
      intWrite <= 1'b0;
      intWdata <= '0;
    end else if (strobe.accept) begin
      intAddr  <= mapAddr;
      intWrite <= hostWrite;
      intWdata <= hostWdata;
    end
  end

  always_comb begin
    rspData = '0;
    if (strobe.ctrlRead)                rspData = ctrlView;
    else if (strobe.capture && !intWrite) rspData = intRdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hostDone  <= 1'b0;
      hostErr   <= 1'b0;
      hostRdata <= '0;
    end else begin
      hostDone  <= strobe.ctrlWrite | strobe.ctrlRead | strobe.fault | strobe.capture;
      hostErr   <= strobe.fault;
      hostRdata <= rspData;
    end
  end

endmodule

// File: rtl/barWindowRemap.sv
module barWindowRemap
  import barWinPkg::*;
#(
  parameter int          APER_W   = 20,
  parameter int          INT_W    = 25,
  parameter int          DATA_W   = 32,
  parameter logic [19:0] CTRL_OFF = 20'h0310C,
  parameter int          EN_POS   = 31
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostReq,
  input  logic              hostWrite,
  input  logic [APER_W-1:0] hostOffset,
  input  logic [DATA_W-1:0] hostWdata,
  output logic              hostBusy,
  output logic              hostDone,
  output logic              hostErr,
  output logic [DATA_W-1:0] hostRdata,
  output logic              intReq,
  output logic              intWrite,
  output logic [INT_W-1:0]  intAddr,
  output logic [DATA_W-1:0] intWdata,
  input  logic              intAck,
  input  logic [DATA_W-1:0] intRdata
);

  winStrobeT strobe;
  logic      hitCtrl;
  logic      hitUpper;
  logic      winEn;
  logic      busy;

  barWinCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .hostReq  (hostReq),
    .hostWrite(hostWrite),
    .hitCtrl  (hitCtrl),
    .hitUpper (hitUpper),
    .winEn    (winEn),
    .intAck   (intAck),
    .strobe   (strobe),
    .busy     (busy)
  );

  barWinPath #(
    .APER_W  (APER_W),
    .INT_W   (INT_W),
    .DATA_W  (DATA_W),
    .CTRL_OFF(CTRL_OFF),
    .EN_POS  (EN_POS)
  ) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .hostWrite (hostWrite),
    .hostOffset(hostOffset),
    .hostWdata (hostWdata),
    .intRdata  (intRdata),
    .hitCtrl   (hitCtrl),
    .hitUpper  (hitUpper),
    .winEn     (winEn),
    .intAddr   (intAddr),
    .intWrite  (intWrite),
    .intWdata  (intWdata),
    .hostDone  (hostDone),
    .hostErr   (hostErr),
    .hostRdata (hostRdata)
  );

  assign hostBusy = busy;
  assign intReq   = busy;

endmodule

// File: rtl/barWinChk.sv
module barWinChk #(
  parameter int          APER_W   = 20,
  parameter int          INT_W    = 25,
  parameter int          DATA_W   = 32,
  parameter logic [19:0] CTRL_OFF = 20'h0310C
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostReq,
  input logic              hostBusy,
  input logic [APER_W-1:0] hostOffset,
  input logic              hostDone,
  input logic              hostErr,
  input logic              intReq,
  input logic              intAck,
  input logic [INT_W-1:0]  intAddr,
  input logic              intWrite,
  input logic [DATA_W-1:0] intWdata,
  input logic              winEn
);

  // R8: request and its fields hold until acknowledged
  a_r8_hold_until_ack: assert property (@(posedge clk) disable iff (!rstN)
    intReq && !intAck |=> intReq && $stable(intAddr) && $stable(intWrite) && $stable(intWdata));

  // R8: acknowledge ends the request and completes the host access
  a_r8_done_after_ack: assert property (@(posedge clk) disable iff (!rstN)
    intReq && intAck |=> hostDone && !hostErr && !intReq);

  // R5: disabled window faults locally
  a_r5_disabled_fault: assert property (@(posedge clk) disable iff (!rstN)
    hostReq && !hostBusy && hostOffset[APER_W-1] && !winEn |=> hostDone && hostErr && !intReq);

  // R5: error only accompanies a completion
  a_r5_err_with_done: assert property (@(posedge clk) disable iff (!rstN)
    hostErr |-> hostDone);

  // R6: window register access stays local
  a_r6_ctrl_local: assert property (@(posedge clk) disable iff (!rstN)
    hostReq && !hostBusy && hostOffset == CTRL_OFF[APER_W-1:0] |=> hostDone && !hostErr && !intReq);

  // R9: a request arriving while busy does not complete the access early
  a_r9_busy_ignores: assert property (@(posedge clk) disable iff (!rstN)
    hostBusy && !intAck |=> hostBusy && !hostDone);

endmodule

bind barWindowRemap barWinChk #(
  .APER_W  (APER_W),
  .INT_W   (INT_W),
  .DATA_W  (DATA_W),
  .CTRL_OFF(CTRL_OFF)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .hostReq   (hostReq),
  .hostBusy  (hostBusy),
  .hostOffset(hostOffset),
  .hostDone  (hostDone),
  .hostErr   (hostErr),
  .intReq    (intReq),
  .intAck    (intAck),
  .intAddr   (intAddr),
  .intWrite  (intWrite),
  .intWdata  (intWdata),
  .winEn     (winEn)
);

// File: tb/sim_barWindowRemap.sv
`timescale 1ns/1ps
module sim_barWindowRemap;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostReq = 1'b0, hostWrite = 1'b0;
  logic [19:0] hostOffset = '0;
  logic [31:0] hostWdata = '0;
  logic        hostBusy, hostDone, hostErr, intReq, intWrite;
  logic [31:0] hostRdata, intWdata;
  logic [24:0] intAddr;
  logic        intAck = 1'b0;
  logic [31:0] intRdata = '0;

  always #2 clk = ~clk;  // 250 MHz

  barWindowRemap u0 (.*);

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // Internal memory environment
  logic [31:0] mem [int];
  int ackLat = 0, waitCnt = 0;

  function automatic logic [31:0] memInit(input logic [24:0] a);
    return {7'h0, a} ^ 32'h5A00_0000;
  endfunction

  function automatic logic [31:0] memGet(input logic [24:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return memInit(a);
  endfunction

  always @(negedge clk) begin
    if (intReq) begin
      if (waitCnt >= ackLat) begin
        intAck   = 1'b1;
        intRdata = intWrite ? 32'hDEAD_0000 : memGet(intAddr);
        if (intWrite) mem[int'(intAddr)] = intWdata;
        waitCnt  = 0;
      end else begin
        intAck = 1'b0;
        waitCnt++;
      end
    end else begin
      intAck  = 1'b0;
      waitCnt = 0;
    end
  end

  // Behavioural reference model, stepped on each rising edge
  bit          mBusy, mWe, mEn, expDone, expErr;
  int          mWin;
  logic [24:0] mAddr;
  logic [31:0] mWd, expRdata;
  string       mTag, rTag;

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mEn = 0; mWin = 0; expDone = 0; expErr = 0; expRdata = '0;
      mTag = "R1"; rTag = "R1";
    end else begin
      expDone = 0; expErr = 0; expRdata = '0;
      if (mBusy) begin
        if (intAck) begin
          expDone = 1; expRdata = mWe ? '0 : intRdata; mBusy = 0; rTag = "R8";
        end
      end else if (hostReq) begin
        if (hostOffset == 20'h0310C) begin
          expDone = 1; rTag = "R4";
          if (hostWrite) begin mEn = hostWdata[31]; mWin = int'(hostWdata[5:0]); end
          else expRdata = (mEn ? 32'h8000_0000 : 0) | mWin;
        end else if (hostOffset >= 20'h80000 && !mEn) begin
          expDone = 1; expErr = 1; rTag = "R5";
        end else begin
          mBusy = 1; mWe = hostWrite; mWd = hostWdata;
          if (hostOffset < 20'h80000) begin mAddr = 25'(hostOffset); mTag = "R2"; end
          else begin mAddr = 25'(mWin * 32'h80000 + (hostOffset - 20'h80000)); mTag = "R3"; end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      chk("R9", 32'(hostBusy), 32'(mBusy), "hostBusy");
      chk(mBusy ? "R8" : "R6", 32'(intReq), 32'(mBusy), "intReq");
      chk(rTag, 32'(hostDone), 32'(expDone), "hostDone");
      chk(rTag, 32'(hostErr), 32'(expErr), "hostErr");
      if (expDone) chk(rTag, hostRdata, expRdata, "hostRdata");
      if (mBusy) begin
        chk(mTag, 32'(intAddr), 32'(mAddr), "intAddr");
        chk("R8", 32'(intWrite), 32'(mWe), "intWrite");
        chk("R8", intWdata, mWd, "intWdata");
      end
    end
  end

  task automatic doAcc(input logic w, input logic [19:0] off, input logic [31:0] d,
                       output logic [31:0] rd, output logic er);
    @(negedge clk);
    while (hostBusy) @(negedge clk);
    hostReq = 1'b1; hostWrite = w; hostOffset = off; hostWdata = d;
    @(negedge clk);
    hostReq = 1'b0;
    while (!hostDone) @(negedge clk);
    rd = hostRdata; er = hostErr;
  endtask

  task automatic finishRun();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      failures++; checks++;
      $display("FAIL watchdog expired actual=%0d expected<20000", cycles);
      finishRun();
    end
  end

  initial begin
    logic [31:0] rd;
    logic        er;
    repeat (3) @(negedge clk);
    // r1_ reset state visible at the ports
    chk("R1", 32'(hostDone), 0, "hostDone in reset");
    chk("R1", 32'(intReq), 0, "intReq in reset");
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", 32'(hostBusy), 0, "hostBusy after reset");
    doAcc(0, 20'h0310C, 0, rd, er);
    chk("R1", rd, 32'h0, "window register after reset");

    // R2 identity map, several latencies
    for (int i = 0; i < 4; i++) begin
      ackLat = i;
      doAcc(0, 20'h00040 + 20'(i * 20'h1234), 0, rd, er);
      chk("R2", rd, memInit(25'(20'h00040 + 20'(i * 20'h1234))), "lower read");
    end
    ackLat = 0;
    doAcc(1, 20'h7FFFC, 32'hCAFE_0001, rd, er);
    chk("R8", rd, 32'h0, "write response data");
    doAcc(0, 20'h7FFFC, 0, rd, er);
    chk("R2", rd, 32'hCAFE_0001, "lower write read back");

    // R5 upper half while disabled
    doAcc(0, 20'h80010, 0, rd, er);
    chk("R5", 32'(er), 1, "disabled read error");
    chk("R5", rd, 0, "disabled read data");
    doAcc(1, 20'h80000, 32'h1111_2222, rd, er);
    chk("R5", 32'(er), 1, "disabled write error");

    // R4 register masking
    doAcc(1, 20'h0310C, 32'h7FFF_FFC0, rd, er);
    doAcc(0, 20'h0310C, 0, rd, er);
    chk("R4", rd, 32'h0, "unused bits read zero");
    doAcc(1, 20'h0310C, 32'hFFFF_FFFF, rd, er);
    chk("R4", rd, 32'h0, "register write response");
    doAcc(0, 20'h0310C, 0, rd, er);
    chk("R4", rd, 32'h8000_003F, "register read back");

    // R3 window 0x3F, top address
    ackLat = 2;
    doAcc(0, 20'hFFFFC, 0, rd, er);
    chk("R3", rd, memInit(25'h1FF_FFFC), "upper read window 3F");
    chk("R3", 32'(er), 0, "no error when enabled");

    // R7 window change applies to next access
    doAcc(1, 20'h0310C, 32'h8000_0015, rd, er);
    doAcc(1, 20'h80123, 32'hBEEF_0015, rd, er);
    doAcc(0, 20'h0310C, 0, rd, er);
    chk("R4", rd, 32'h8000_0015, "window 15 read back");
    doAcc(1, 20'h0310C, 32'h8000_0002, rd, er);
    doAcc(0, 20'h80123, 0, rd, er);
    chk("R7", rd, memInit({6'h02, 19'h00123}), "next access uses window 2");
    doAcc(1, 20'h0310C, 32'h8000_0015, rd, er);
    doAcc(0, 20'h80123, 0, rd, er);
    chk("R7", rd, 32'hBEEF_0015, "next access uses window 15");
    chk("R3", 32'(mem.exists(int'({6'h15, 19'h00123}))), 1, "write landed at windowed address");

    // R9 request while busy is ignored
    ackLat = 4;
    @(negedge clk);
    hostReq = 1; hostWrite = 0; hostOffset = 20'h00200;
    @(negedge clk);
    hostWrite = 1; hostOffset = 20'h0310C; hostWdata = 32'h0;
    @(negedge clk);
    hostReq = 0;
    while (!hostDone) @(negedge clk);
    ackLat = 0;
    doAcc(0, 20'h0310C, 0, rd, er);
    chk("R9", rd, 32'h8000_0015, "register untouched by busy request");

    // back-to-back disable then fault
    doAcc(1, 20'h0310C, 32'h0000_0015, rd, er);
    doAcc(0, 20'h80123, 0, rd, er);
    chk("R7", 32'(er), 1, "disable applies to next access");

    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule